// File: doc/BRIEF.md
# Serial Timeslot Unpacker and Packer with Side-Bit Separation

This block sits between a serial time-division multiplexed bus and a per-channel byte-processing stage such as a gain pad. The bus carries frames of 32 timeslots. Each timeslot is 10 bits long: an 8-bit voice or data byte and two side bits. One side bit carries channel signaling and the other says whether the byte is valid. At 2.56 Mb/s a frame is 320 bits long and repeats at 8 kHz, so each slot gives 64 kb/s of data and 8 kb/s on each side bit.

On the receive side the block rebuilds each byte from the serial line. At the end of every slot it presents the byte, the signaling bit, the valid bit and the slot number together with a one-cycle strobe. Two timeslots, 0 and 16, carry no PCM traffic, and a flag marks them as non-PCM. On the transmit side the block asks for the next slot's byte and side bits one bit time before that slot begins. It then shifts them out with no gaps. Slots 0 and 16 are always sent as an idle pattern.

A one-clock frame-sync pulse marks the first bit of slot 0. If the pulse arrives anywhere other than the expected frame start, the block flags an error and realigns to the new pulse.

Top module: `tdm_slot_codec`

## Requirements
- R1: While reset is low and in the first cycle after it is released, `rx_strobe`, `sync_err` and `ser_out` are 0.
- R2: The cycle in which `frame_sync` is high carries bit 0 of slot 0. Each slot lasts 10 clock cycles and a frame has 32 slots, so every complete slot produces exactly one receive strobe.
- R3: Within a slot, bits 0 to 7 are the data byte with the most significant bit first, bit 8 is the signaling bit and bit 9 is the valid bit. This order applies on both `ser_in` and `ser_out`.
- R4: `rx_strobe` is high for exactly one cycle: the cycle after the one carrying bit 9 of a slot. In that cycle `rx_byte`, `rx_sig`, `rx_valid` and `rx_slot` describe that slot. These outputs hold their values until the next strobe. A slot that is cut short by a new frame sync produces no strobe.
- R5: `rx_pcm` is 0 in the strobe of slot 0 and slot 16, and 1 in the strobe of every other slot.
- R6: The first `frame_sync` after reset and any `frame_sync` that falls exactly at the expected frame start raise no error. Once a frame sync has been seen, a `frame_sync` at any other bit position makes `sync_err` high for exactly the following cycle, and counting restarts from that pulse.
- R7: `tx_load` is high exactly in the cycle that carries bit 9 of a slot. In that cycle `tx_load_slot` gives the index of the next slot, with 31 wrapping to 0, and `tx_byte`, `tx_sig` and `tx_valid` are sampled for that slot.
- R8: In the cycle that carries bit k of slot s, `ser_out` carries bit k (ordered as in R3) of the word loaded for slot s, with no gap between slots.
- R9: Slots 0 and 16 are transmitted as data 8'hFF with signaling 0 and valid 0, whatever is on `tx_byte`, `tx_sig` and `tx_valid`.
- R10: Without a further `frame_sync`, framing keeps running on a 320-cycle period and slot numbering continues from 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one bus bit per cycle |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_sync | input | 1 | High in the cycle that carries bit 0 of slot 0 |
| ser_in | input | 1 | Received serial bit |
| tx_byte | input | 8 | Byte for the slot named by `tx_load_slot`, sampled while `tx_load` is high |
| tx_sig | input | 1 | Signaling bit for that slot |
| tx_valid | input | 1 | Valid bit for that slot |
| rx_byte | output | 8 | Received data byte |
| rx_slot | output | 5 | Index of the received slot |
| rx_sig | output | 1 | Received signaling bit |
| rx_valid | output | 1 | Received valid bit |
| rx_pcm | output | 1 | 0 for the non-PCM slots 0 and 16 |
| rx_strobe | output | 1 | One-cycle marker that the receive outputs are new |
| tx_load | output | 1 | High in the cycle in which the transmit inputs are sampled |
| tx_load_slot | output | 5 | Slot whose transmit word is being loaded |
| ser_out | output | 1 | Transmitted serial bit |
| sync_err | output | 1 | One-cycle pulse after a misplaced frame sync |

## Verification
The receive path is fed frames whose byte and side-bit patterns change from slot to slot and from frame to frame. Because these patterns differ, a swapped bit order, a shifted slot index or a signaling/valid mix-up each show up as a mismatch in the scoreboard. The transmit path is driven with slot-dependent words and checked bit by bit. These words differ from the idle pattern, so forcing idle on the wrong slots, or failing to force it on slots 0 and 16, is detected. The framing is tried four ways: with a first sync, with a sync at the expected frame start, with a frame that has no sync at all, and with a sync that cuts a frame short. Together these separate correct realignment and error reporting from a counter that simply resets on every pulse or that flags every pulse.

// File: rtl/tdm_slot_pkg.sv
// Package: shared defaults and the slot-phase type for the timeslot codec.
// Assumes each slot is a data field followed by one signaling and one valid bit.
package tdm_slot_pkg;

    localparam int DEF_SLOTS     = 32;
    localparam int DEF_DATA_BITS = 8;
    localparam int DEF_IDLE_A    = 0;
    localparam int DEF_IDLE_B    = 16;

    // Which field of the slot word the current bit belongs to.
    typedef enum logic [1:0] {
        PH_DATA  = 2'd0,
        PH_SIG   = 2'd1,
        PH_VALID = 2'd2
    } slot_phase_e;

endpackage

// File: rtl/tdm_slot_timer.sv
// Module: bit and slot position tracker.
// What it does: gives the position of the current cycle within the frame,
// realigns on frame sync, and flags a sync pulse that arrives off-position.
// Assumes: frame_sync is one cycle wide and marks bit 0 of slot 0.
module tdm_slot_timer
    import tdm_slot_pkg::*;
#(
    parameter int SLOTS     = DEF_SLOTS,
    parameter int DATA_BITS = DEF_DATA_BITS,
    localparam int SLOT_BITS = DATA_BITS + 2,
    localparam int BW        = $clog2(SLOT_BITS),
    localparam int SW        = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_sync,
    output logic [SW-1:0] cur_slot,
    output slot_phase_e   phase,
    output logic          last_bit,
    output logic [SW-1:0] next_slot,
    output logic          sync_err
);

    localparam logic [BW-1:0] BIT_LAST  = BW'(SLOT_BITS - 1);
    localparam logic [BW-1:0] BIT_SIG   = BW'(DATA_BITS);
    localparam logic [SW-1:0] SLOT_LAST = SW'(SLOTS - 1);

    logic [BW-1:0] bit_q;
    logic [SW-1:0] slot_q;
    logic [BW-1:0] cur_bit;
    logic          locked_q;

    // Current position: a sync pulse forces slot 0, bit 0.
    always_comb begin
        cur_bit  = frame_sync ? '0 : bit_q;
        cur_slot = frame_sync ? '0 : slot_q;
    end

    // Decode the field of the current bit and the slot that follows.
    always_comb begin
        if (cur_bit < BIT_SIG) begin
            phase = PH_DATA;
        end else if (cur_bit == BIT_SIG) begin
            phase = PH_SIG;
        end else begin
            phase = PH_VALID;
        end
        last_bit  = (cur_bit == BIT_LAST);
        next_slot = (cur_slot == SLOT_LAST) ? '0 : cur_slot + SW'(1);
    end

    // Advance the counters by one bit position every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q  <= '0;
            slot_q <= '0;
        end else if (last_bit) begin
            bit_q  <= '0;
            slot_q <= next_slot;
        end else begin
            bit_q  <= cur_bit + BW'(1);
            slot_q <= cur_slot;
        end
    end

    // Track lock and flag a sync pulse that arrives away from the frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked_q <= 1'b0;
            sync_err <= 1'b0;
        end else begin
            locked_q <= locked_q | frame_sync;
            sync_err <= frame_sync && locked_q && ((bit_q != '0) || (slot_q != '0));
        end
    end

    AST_SYNC_REALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |=> (bit_q == BW'(1) && slot_q == '0)); // R6
    AST_BIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_sync && bit_q != BIT_LAST) |=> (bit_q == $past(bit_q) + BW'(1))); // R2
    AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_sync && bit_q == BIT_LAST && slot_q == SLOT_LAST) |=> (slot_q == '0)); // R10
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err |-> $past(frame_sync)); // R6

endmodule

// File: rtl/tdm_rx_unpack.sv
// Module: receive unpacker.
// What it does: shifts the data bits into a byte (MSB first), holds the
// signaling bit, and on the valid bit publishes the whole slot with a strobe.
// Assumes: the phase input comes from the position tracker and is in step with ser_in.
module tdm_rx_unpack
    import tdm_slot_pkg::*;
#(
    parameter int SLOTS     = DEF_SLOTS,
    parameter int DATA_BITS = DEF_DATA_BITS,
    parameter int IDLE_A    = DEF_IDLE_A,
    parameter int IDLE_B    = DEF_IDLE_B,
    localparam int SW       = $clog2(SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ser_in,
    input  slot_phase_e          phase,
    input  logic [SW-1:0]        cur_slot,
    output logic [DATA_BITS-1:0] rx_byte,
    output logic [SW-1:0]        rx_slot,
    output logic                 rx_sig,
    output logic                 rx_valid,
    output logic                 rx_pcm,
    output logic                 rx_strobe
);

    logic [DATA_BITS-1:0] shift_q;
    logic                 sig_q;
    logic                 slot_is_pcm;

    // Slots reserved for framing and signaling carry no PCM.
    always_comb begin
        slot_is_pcm = (cur_slot != SW'(IDLE_A)) && (cur_slot != SW'(IDLE_B));
    end

    // Collect data bits and the signaling bit as they arrive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
            sig_q   <= 1'b0;
        end else if (phase == PH_DATA) begin
            shift_q <= {shift_q[DATA_BITS-2:0], ser_in};
        end else if (phase == PH_SIG) begin
            sig_q <= ser_in;
        end
    end

    // Publish the finished slot on its valid bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_byte   <= '0;
            rx_slot   <= '0;
            rx_sig    <= 1'b0;
            rx_valid  <= 1'b0;
            rx_pcm    <= 1'b0;
            rx_strobe <= 1'b0;
        end else begin
            rx_strobe <= (phase == PH_VALID);
            if (phase == PH_VALID) begin
                rx_byte  <= shift_q;
                rx_slot  <= cur_slot;
                rx_sig   <= sig_q;
                rx_valid <= ser_in;
                rx_pcm   <= slot_is_pcm;
            end
        end
    end

    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe |=> !rx_strobe); // R4
    AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_VALID) |=> $stable(rx_byte) && $stable(rx_slot)); // R4

endmodule

// File: rtl/tdm_tx_pack.sv
// Module: transmit packer.
// What it does: loads the next slot's word on the last bit of the current
// slot and shifts it out MSB first, forcing the idle word on reserved slots.
// Assumes: the source presents its word in the cycle where last_bit is high.
module tdm_tx_pack
    import tdm_slot_pkg::*;
#(
    parameter int SLOTS     = DEF_SLOTS,
    parameter int DATA_BITS = DEF_DATA_BITS,
    parameter int IDLE_A    = DEF_IDLE_A,
    parameter int IDLE_B    = DEF_IDLE_B,
    parameter logic [DATA_BITS-1:0] IDLE_PATTERN = '1,
    localparam int SLOT_BITS = DATA_BITS + 2,
    localparam int SW        = $clog2(SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 last_bit,
    input  logic [SW-1:0]        next_slot,
    input  logic [DATA_BITS-1:0] tx_byte,
    input  logic                 tx_sig,
    input  logic                 tx_valid,
    output logic                 ser_out
);

    logic [SLOT_BITS-1:0] word_q;
    logic [SLOT_BITS-1:0] load_word;
    logic                 next_idle;

    // Choose the idle word for reserved slots, the caller's word otherwise.
    always_comb begin
        next_idle = (next_slot == SW'(IDLE_A)) || (next_slot == SW'(IDLE_B));
        load_word = next_idle ? {IDLE_PATTERN, 1'b0, 1'b0}
                              : {tx_byte, tx_sig, tx_valid};
    end

    // Load at the slot boundary, shift left on every other bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (last_bit) begin
            word_q <= load_word;
        end else begin
            word_q <= {word_q[SLOT_BITS-2:0], 1'b0};
        end
    end

    always_comb begin
        ser_out = word_q[SLOT_BITS-1];
    end

    AST_IDLE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (last_bit && next_idle) |=> (ser_out == IDLE_PATTERN[DATA_BITS-1])); // R9
    AST_LOAD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (last_bit && !next_idle) |=> (ser_out == $past(tx_byte[DATA_BITS-1]))); // R7

endmodule

// File: rtl/tdm_slot_codec.sv
// Module: timeslot codec top.
// What it does: ties the position tracker, receive unpacker and transmit
// packer to one serial bus of fixed-length slots.
// Assumes: one bus bit per clock, and a one-cycle frame sync at bit 0 of slot 0.
module tdm_slot_codec
    import tdm_slot_pkg::*;
#(
    parameter int SLOTS     = DEF_SLOTS,
    parameter int DATA_BITS = DEF_DATA_BITS,
    parameter int IDLE_A    = DEF_IDLE_A,
    parameter int IDLE_B    = DEF_IDLE_B,
    parameter logic [DATA_BITS-1:0] IDLE_PATTERN = '1,
    localparam int SW = $clog2(SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_sync,
    input  logic                 ser_in,
    input  logic [DATA_BITS-1:0] tx_byte,
    input  logic                 tx_sig,
    input  logic                 tx_valid,
    output logic [DATA_BITS-1:0] rx_byte,
    output logic [SW-1:0]        rx_slot,
    output logic                 rx_sig,
    output logic                 rx_valid,
    output logic                 rx_pcm,
    output logic                 rx_strobe,
    output logic                 tx_load,
    output logic [SW-1:0]        tx_load_slot,
    output logic                 ser_out,
    output logic                 sync_err
);

    logic [SW-1:0] cur_slot;
    logic [SW-1:0] next_slot;
    slot_phase_e   phase;
    logic          last_bit;

    tdm_slot_timer #(
        .SLOTS     (SLOTS),
        .DATA_BITS (DATA_BITS)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_sync (frame_sync),
        .cur_slot   (cur_slot),
        .phase      (phase),
        .last_bit   (last_bit),
        .next_slot  (next_slot),
        .sync_err   (sync_err)
    );

    tdm_rx_unpack #(
        .SLOTS     (SLOTS),
        .DATA_BITS (DATA_BITS),
        .IDLE_A    (IDLE_A),
        .IDLE_B    (IDLE_B)
    ) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_in    (ser_in),
        .phase     (phase),
        .cur_slot  (cur_slot),
        .rx_byte   (rx_byte),
        .rx_slot   (rx_slot),
        .rx_sig    (rx_sig),
        .rx_valid  (rx_valid),
        .rx_pcm    (rx_pcm),
        .rx_strobe (rx_strobe)
    );

    tdm_tx_pack #(
        .SLOTS        (SLOTS),
        .DATA_BITS    (DATA_BITS),
        .IDLE_A       (IDLE_A),
        .IDLE_B       (IDLE_B),
        .IDLE_PATTERN (IDLE_PATTERN)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .last_bit  (last_bit),
        .next_slot (next_slot),
        .tx_byte   (tx_byte),
        .tx_sig    (tx_sig),
        .tx_valid  (tx_valid),
        .ser_out   (ser_out)
    );

    // Expose the load request for the transmit source.
    always_comb begin
        tx_load      = last_bit;
        tx_load_slot = next_slot;
    end

    AST_STROBE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe |-> $past(last_bit)); // R4
    AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |=> !tx_load); // R7

endmodule

// File: tb/tdm_slot_codec_tb.sv
module tdm_slot_codec_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_sync = 1'b0;
    logic       ser_in = 1'b0;
    logic [7:0] tx_byte;
    logic       tx_sig;
    logic       tx_valid;
    logic [7:0] rx_byte;
    logic [4:0] rx_slot;
    logic       rx_sig, rx_valid, rx_pcm, rx_strobe;
    logic       tx_load;
    logic [4:0] tx_load_slot;
    logic       ser_out, sync_err;

    int checks = 0;
    int failures = 0;
    int strobes = 0;
    int pushes = 0;
    int errs = 0;
    logic [7:0] tx_salt = 8'h00;
    logic [15:0] exp_q[$];

    always #2.5 clk = ~clk;

    tdm_slot_codec u_dut (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .ser_in(ser_in),
        .tx_byte(tx_byte), .tx_sig(tx_sig), .tx_valid(tx_valid),
        .rx_byte(rx_byte), .rx_slot(rx_slot), .rx_sig(rx_sig), .rx_valid(rx_valid),
        .rx_pcm(rx_pcm), .rx_strobe(rx_strobe), .tx_load(tx_load),
        .tx_load_slot(tx_load_slot), .ser_out(ser_out), .sync_err(sync_err)
    );

    function automatic logic [7:0] tx_b(input logic [4:0] s, input logic [7:0] salt);
        return ({3'b0, s} * 8'd13) ^ salt ^ 8'h5A;
    endfunction

    // Transmit source: answers the load request from the slot it names (R7).
    always_comb begin
        tx_byte  = tx_b(tx_load_slot, tx_salt);
        tx_sig   = tx_load_slot[0];
        tx_valid = ~tx_load_slot[1];
    end

    function automatic logic exp_tx_bit(input int s, input int k, input logic [7:0] salt);
        logic [9:0] w;
        logic [4:0] s5;
        s5 = 5'(s);
        if (s == 0 || s == 16) w = {8'hFF, 1'b0, 1'b0};
        else w = {tx_b(s5, salt), s5[0], ~s5[1]};
        return w[9-k];
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: sends one frame (possibly cut short) and queues expected slots.
    task automatic drive_frame(input int full_slots, input int tail_bits, input bit with_sync,
                               input bit chk_tx, input bit exp_err, input logic [7:0] salt);
        tx_salt = salt;
        for (int s = 0; s < 32; s++) begin
            int nb;
            logic [4:0] s5;
            logic [9:0] w;
            s5 = 5'(s);
            w = {(8'(s) * 8'd37) + salt, s5[0] ^ salt[0], s5[2] ^ salt[1]};
            nb = (s < full_slots) ? 10 : ((s == full_slots) ? tail_bits : 0);
            if (nb == 0) break;
            for (int k = 0; k < nb; k++) begin
                @(negedge clk);
                if (with_sync && s == 0 && k == 1)
                    check(sync_err == exp_err, "R6 sync_err", 32'(sync_err), 32'(exp_err));
                if (chk_tx)
                    check(ser_out == exp_tx_bit(s, k, salt),
                          (s == 0 || s == 16) ? "R9 idle ser_out" : "R8 ser_out",
                          32'(ser_out), 32'(exp_tx_bit(s, k, salt)));
                if (k == 9)
                    check(tx_load && tx_load_slot == 5'(s + 1), "R7 tx_load at bit 9",
                          {26'b0, tx_load, tx_load_slot}, {26'b0, 1'b1, 5'(s + 1)});
                if (k == 4)
                    check(!tx_load, "R7 tx_load mid-slot", 32'(tx_load), 32'd0);
                frame_sync = with_sync && s == 0 && k == 0;
                ser_in = w[9-k];
            end
            if (nb == 10) begin
                exp_q.push_back({s5, w, (s != 0 && s != 16)});
                pushes++;
            end
        end
    endtask

    // Monitor: compares every published slot against the scoreboard.
    always @(negedge clk) begin
        if (rst_n) begin
            if (sync_err) errs++;
            if (rx_strobe) begin
                strobes++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4 strobe with nothing expected", 32'(rx_slot), 32'hFFFF);
                end else begin
                    logic [15:0] e;
                    logic [15:0] a;
                    e = exp_q.pop_front();
                    a = {rx_slot, rx_byte, rx_sig, rx_valid, rx_pcm};
                    check(a == e, "R3 R4 R5 slot contents", 32'(a), 32'(e));
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check(!rx_strobe && !sync_err && !ser_out, "R1 in reset",
              {29'b0, rx_strobe, sync_err, ser_out}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!rx_strobe && !sync_err && !ser_out, "R1 after reset",
              {29'b0, rx_strobe, sync_err, ser_out}, 32'd0);
        drive_frame(32, 0, 1'b1, 1'b0, 1'b0, 8'h01); // first sync: no error (R6)
        drive_frame(32, 0, 1'b1, 1'b1, 1'b0, 8'h02); // sync on time
        drive_frame(32, 0, 1'b0, 1'b1, 1'b0, 8'hC3); // R10 free-running frame
        drive_frame(5, 3, 1'b1, 1'b1, 1'b0, 8'h3C);  // cut short by next sync
        drive_frame(32, 0, 1'b1, 1'b0, 1'b1, 8'hA5); // misplaced sync: error, realign
        drive_frame(32, 0, 1'b1, 1'b1, 1'b0, 8'hFF); // aligned again
        frame_sync = 1'b0;
        ser_in = 1'b0;
        repeat (3) @(negedge clk);
        check(strobes == 32 * 5 + 5, "R2 one strobe per complete slot", 32'(strobes), 32'(32 * 5 + 5));
        check(exp_q.size() == 0, "R10 all slots delivered", 32'(exp_q.size()), 32'd0);
        check(errs == 1, "R6 sync error count", 32'(errs), 32'd1);
        check(pushes == strobes, "R4 strobe count", 32'(strobes), 32'(pushes));
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule